// File: doc/BRIEF.md
# PI Phase Tracker with Step Pulses

This block closes a phase-tracking loop around an external phase shifter that accepts only single-step up and down commands. A signed phase-error sample arrives at a low rate, nominally every 20 µs. On each accepted sample the block applies a proportional-integral law to find the phase it wants. The difference between that wanted phase and its own current-phase count becomes a pending step count. The block then works off the pending count as a train of one-cycle pulses on an up or a down line. Each pulse moves the current-phase count by one, so the count always matches the number of steps the shifter has received.

The current phase is reported as a step count that wraps modulo a configurable steps-per-period value (for example 10000 steps of 100 ps at a 1 MHz modulation rate). Its low byte is driven to a DAC port so that loop jitter can be watched on an analog output. The two gains are signed Q8.8 inputs. An enable input freezes the loop.

Top module: `pi_step_tracker`

## Requirements
- R1: After reset, `phase` is 0, `dac_out` is 0, `busy` is 0 and neither step line is high.
- R2: A sample is taken at a clock edge where `enable` and `smp_valid` are both high. The pending count becomes floor((kp*e + ki*(phase+e)) / 256) - phase. Here e is `smp_err`, `kp` and `ki` are signed two's-complement with 8 fractional bits (256 = 1.0), and `phase` is read as an unsigned value.
- R3: A positive pending count N produces exactly N pulses on `step_up`, and a negative count -N produces exactly N pulses on `step_dn`. `busy` is high while pulses are still owed.
- R4: `step_up` and `step_dn` are never high in the same cycle.
- R5: Each pulse lasts one cycle and is followed by at least one low cycle. The first pulse appears in the cycle after the edge that took the sample.
- R6: Each `step_up` pulse adds one to `phase` and each `step_dn` pulse subtracts one, in the same cycle as the pulse.
- R7: `phase` wraps modulo `period_steps`: an up step from `period_steps`-1 gives 0, and a down step from 0 gives `period_steps`-1.
- R8: A sample taken while pulses are still owed replaces the remaining count with one computed from the phase at that moment. No pulse is issued at the edge that takes the sample.
- R9: While `enable` is low the pending count is cleared, `phase` holds, no pulses are issued and samples are ignored. Raising `enable` again does not resume the cancelled pulses.
- R10: The pending count saturates at +32767 and -32767 steps.
- R11: `dac_out` always equals the low 8 bits of `phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Loop enable |
| smp_valid | input | 1 | One-cycle strobe marking a new error sample |
| smp_err | input | 12 | Signed phase-error sample |
| kp | input | 16 | Proportional gain, signed Q8.8 |
| ki | input | 16 | Integral gain, signed Q8.8 |
| period_steps | input | 16 | Steps in one full period (wrap modulus) |
| step_up | output | 1 | One-cycle step-up pulse to the phase shifter |
| step_dn | output | 1 | One-cycle step-down pulse to the phase shifter |
| phase | output | 16 | Current phase as a step count |
| dac_out | output | 8 | Low byte of the phase, for a DAC |
| busy | output | 1 | Pulses still owed |

## Verification
The sample edge loads the pending count, so `busy` rises in the cycle after that edge. The first pulse and its phase change follow one edge later, and pulse k lands two cycles after pulse k-1, so a count of N is fully settled 2N cycles after the sample edge. Every scenario drives inputs on falling edges and reads outputs on falling edges. It waits at least 2N+4 cycles before checking the final phase and the pulse totals. A falling-edge monitor counts pulses and flags any back-to-back or overlapping pulses. The preemption and enable scenarios count falling edges exactly, so the second sample or the enable drop lands after a known number of pulses.

// File: rtl/pi_step_tracker.sv
module pi_step_tracker #(
  parameter int ERR_W  = 12,
  parameter int GAIN_W = 16,
  parameter int PH_W   = 16,
  parameter int FRAC   = 8,
  parameter int DAC_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     smp_valid,
  input  logic signed [ERR_W-1:0]  smp_err,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic [PH_W-1:0]          period_steps,
  output logic                     step_up,
  output logic                     step_dn,
  output logic [PH_W-1:0]          phase,
  output logic [DAC_W-1:0]         dac_out,
  output logic                     busy
);

  localparam int CE_W  = PH_W + 2;
  localparam int SUM_W = GAIN_W + CE_W + 2;
  localparam logic signed [SUM_W-1:0] LIM = SUM_W'((64'sd1 <<< (PH_W-1)) - 64'sd1);

  logic signed [PH_W-1:0]  pend;
  logic signed [CE_W-1:0]  c_plus_e;
  logic signed [SUM_W-1:0] p_term, i_term, sum_t, want, diff;
  logic signed [PH_W-1:0]  clamped;
  logic [PH_W-1:0]         ph_inc, ph_dec;
  logic                    take, pulse_ok;

  assign c_plus_e = $signed({2'b00, phase}) + CE_W'(smp_err);
  assign p_term   = SUM_W'(kp) * SUM_W'(smp_err);
  assign i_term   = SUM_W'(ki) * SUM_W'(c_plus_e);
  assign sum_t    = p_term + i_term;
  assign want     = sum_t >>> FRAC;
  assign diff     = want - $signed({{(SUM_W-PH_W){1'b0}}, phase});

  always_comb begin
    if (diff > LIM)       clamped = PH_W'(LIM);
    else if (diff < -LIM) clamped = PH_W'(-LIM);
    else                  clamped = PH_W'(diff);
  end

  assign ph_inc   = (phase >= period_steps - 1'b1) ? '0 : phase + 1'b1;
  assign ph_dec   = (phase == '0) ? period_steps - 1'b1 : phase - 1'b1;
  assign take     = enable && smp_valid;
  assign pulse_ok = enable && !smp_valid && (pend != '0) && !step_up && !step_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      phase   <= '0;
      step_up <= 1'b0;
      step_dn <= 1'b0;
    end else begin
      step_up <= 1'b0;
      step_dn <= 1'b0;
      if (!enable) begin
        pend <= '0;
      end else if (take) begin
        pend <= clamped;
      end else if (pulse_ok) begin
        if (pend > 0) begin
          step_up <= 1'b1;
          phase   <= ph_inc;
          pend    <= pend - PH_W'(1);
        end else begin
          step_dn <= 1'b1;
          phase   <= ph_dec;
          pend    <= pend + PH_W'(1);
        end
      end
    end
  end

  assign busy    = (pend != '0);
  assign dac_out = phase[DAC_W-1:0];

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |=> !(step_up || step_dn));

  a_r6_up_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && phase != '0) |-> (phase == $past(phase) + 1'b1));

  a_r6_dn_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && $past(phase) != '0) |-> (phase == $past(phase) - 1'b1));

  a_r9_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(phase) && !step_up && !step_dn && !busy));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !(step_up || step_dn));

  a_r8_no_pulse_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && smp_valid) |=> !(step_up || step_dn));

endmodule

// File: tb/pi_step_tracker_tb.sv
module pi_step_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [11:0] smp_err = '0;
  logic signed [15:0] kp = '0;
  logic signed [15:0] ki = 16'sd256;
  logic [15:0] period_steps = 16'd10000;
  logic step_up, step_dn, busy;
  logic [15:0] phase;
  logic [7:0] dac_out;

  int tests = 0, fails = 0;
  int n_up = 0, n_dn = 0, n_gap = 0, n_both = 0;
  logic prev_pulse = 1'b0;
  int cyc = 0;

  pi_step_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
    .smp_err(smp_err), .kp(kp), .ki(ki), .period_steps(period_steps),
    .step_up(step_up), .step_dn(step_dn), .phase(phase),
    .dac_out(dac_out), .busy(busy)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (step_up) n_up++;
      if (step_dn) n_dn++;
      if (step_up && step_dn) n_both++;
      if ((step_up || step_dn) && prev_pulse) n_gap++;
      prev_pulse = step_up || step_dn;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: cycles act=%0d exp<=190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send_sample(input int e);
    smp_err = 12'(e);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check(phase == 0, "R1 phase", phase, 0);
    check(dac_out == 0, "R1 dac_out", dac_out, 0);
    check(!busy && !step_up && !step_dn, "R1 idle", {busy, step_up, step_dn}, 0);
  endtask

  task automatic t_basic_up;
    int u0;
    u0 = n_up;
    kp = 0; ki = 256;
    send_sample(5);
    check(busy && !step_up, "R5 no pulse on sample cycle", step_up, 0);
    @(negedge clk);
    check(step_up == 1'b1, "R5 first pulse next cycle", step_up, 1);
    check(phase == 1, "R6 phase moves with pulse", phase, 1);
    wait_cyc(12);
    check(n_up - u0 == 5, "R3 up pulse count", n_up - u0, 5);
    check(phase == 5, "R2 phase after e=5", phase, 5);
    check(!busy, "R3 busy drops", busy, 0);
  endtask

  task automatic t_basic_down;
    int d0;
    d0 = n_dn;
    send_sample(-3);
    wait_cyc(10);
    check(n_dn - d0 == 3, "R3 down pulse count", n_dn - d0, 3);
    check(phase == 2, "R6 phase after down", phase, 2);
  endtask

  task automatic t_prop_gain;
    kp = 128; ki = 256;
    send_sample(4);
    wait_cyc(16);
    check(phase == 8, "R2 kp=0.5 e=4 gives +6", phase, 8);
    send_sample(-3);
    wait_cyc(14);
    check(phase == 3, "R2 floor of -4.5 gives -5", phase, 3);
  endtask

  task automatic t_int_half;
    int u0, d0;
    u0 = n_up; d0 = n_dn;
    kp = 0; ki = 128;
    send_sample(4);
    wait_cyc(8);
    check(n_up == u0 && n_dn == d0, "R2 ki=0.5 wanted equals current", n_up - u0 + n_dn - d0, 0);
    check(phase == 3, "R2 phase unchanged", phase, 3);
    ki = 256;
  endtask

  task automatic t_wrap;
    period_steps = 16'd10;
    send_sample(8);
    wait_cyc(20);
    check(phase == 1, "R7 up wrap", phase, 1);
    send_sample(-3);
    wait_cyc(10);
    check(phase == 8, "R7 down wrap", phase, 8);
    check(dac_out == 8, "R11 dac_out low byte", dac_out, 8);
    period_steps = 16'd10000;
  endtask

  task automatic t_preempt;
    int u0, d0;
    u0 = n_up; d0 = n_dn;
    send_sample(20);
    wait_cyc(3);
    send_sample(-1);
    wait_cyc(10);
    check(n_up - u0 == 2, "R8 ups before replace", n_up - u0, 2);
    check(n_dn - d0 == 1, "R8 downs after replace", n_dn - d0, 1);
    check(phase == 9, "R8 phase after replace", phase, 9);
  endtask

  task automatic t_enable;
    int u0;
    u0 = n_up;
    send_sample(10);
    @(negedge clk);
    enable = 1'b0;
    wait_cyc(20);
    check(n_up - u0 == 1, "R9 pulses stop", n_up - u0, 1);
    check(phase == 10, "R9 phase holds", phase, 10);
    send_sample(5);
    wait_cyc(10);
    check(phase == 10 && !busy, "R9 sample ignored", phase, 10);
    enable = 1'b1;
    wait_cyc(20);
    check(phase == 10 && n_up - u0 == 1, "R9 no resume", phase, 10);
    check(dac_out == 10, "R11 dac_out follows", dac_out, 10);
  endtask

  task automatic t_saturate;
    int u0;
    u0 = n_up;
    period_steps = 16'd40000;
    kp = 16'sh7FFF; ki = 256;
    send_sample(2047);
    wait_cyc(65540);
    check(n_up - u0 == 32767, "R10 positive clamp", n_up - u0, 32767);
    check(phase == 32777, "R10 phase after clamp", phase, 32777);
    check(!busy, "R10 busy clears", busy, 0);
  endtask

  initial begin
    wait_cyc(4);
    t_reset();
    rst_n = 1'b1;
    enable = 1'b1;
    wait_cyc(2);
    t_reset();
    t_basic_up();
    t_basic_down();
    t_prop_gain();
    t_int_half();
    t_wrap();
    t_preempt();
    t_enable();
    t_saturate();
    check(n_both == 0, "R4 no overlap", n_both, 0);
    check(n_gap == 0, "R5 spacing", n_gap, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule